// File: doc/BRIEF.md
# Bit-Addressable Low I/O Window

This block is the bus front end of a small I/O register file. It has two address regions. The bottom 32 byte locations take whole-byte reads and writes, and they also take single-bit set and single-bit clear commands that name one bit. Every location from 0x20 upward takes whole-byte access only. A group of general-purpose port register banks lives in the byte-only region. Each bank has a direction register, an output register, a sampled input register and a change-flag register, plus set, clear and toggle strobe addresses for direction and output.

Four registers of each bank are mirrored into the low window as aliases. These are direction, output, input and flag. An access through an alias reaches the same physical register as the matching full-map address, so a processor can use fast single-bit commands on the port registers it touches most. The locations at the very bottom of the window belong to the processor core and map to nothing here.

The byte port and the bit-command port work in parallel. A bit command aimed above the window is rejected with a one-cycle error pulse.

Top module: `lowio_window`

## Requirements
- R1: After reset, every direction, output, input and flag register is 0x00. err_o is 0, and a read of any address returns 0x00.
- R2: Port p (p < NPORTS) has its full-map bank at byte address 0x40 + 16*p. The offsets are: 0 direction, 1 direction-set, 2 direction-clear, 3 direction-toggle, 4 output, 5 output-set, 6 output-clear, 7 output-toggle, 8 input, 9 flag. The set, clear and toggle strobes OR, AND-NOT and XOR the written byte into the base register. A read of any strobe address returns its base register. A write (req_i=1, we_i=1) takes effect at the next rising clock edge. A read (req_i=1, we_i=0) returns data on rdata_o in the same cycle.
- R3: The low-window aliases of port p sit at 0x04 + 4*p: +0 direction, +1 output, +2 input, +3 flag. A byte write through an alias changes the same register as a write to its full-map address. A read from either address returns the same value.
- R4: A bit command takes bop_valid_i=1, bop_addr_i, bop_idx_i (0..7) and bop_set_i (1 = set, 0 = clear). When it hits a direction or output alias, it changes exactly bit bop_idx_i at the next clock edge and leaves the other seven bits unchanged.
- R5: A bit command with bop_addr_i >= 0x20 changes no register and drives err_o high for exactly the cycle after the command's clock edge.
- R6: Low addresses 0x00 to 0x03, and low addresses not covered by an existing port alias, read as 0x00. Byte writes and bit commands to them change nothing and raise no error.
- R7: Each input register loads its pin_i byte at every clock edge. Byte writes and bit commands aimed at it are ignored.
- R8: A flag bit sets on the edge after its input register bit goes from 0 to 1. A byte write to the flag clears the bits written as 1. A bit-set command on the flag alias clears that one bit. A bit-clear command on the flag alias has no effect.
- R9: When a byte write and a bit command reach the same register group (direction group, output group or flag) in one cycle, the byte write is applied and the bit command is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Byte access request |
| we_i | input | 1 | Byte access is a write |
| addr_i | input | ADDR_W | Byte access address |
| wdata_i | input | 8 | Byte write data |
| rdata_o | output | 8 | Byte read data, combinational |
| bop_valid_i | input | 1 | Bit command valid |
| bop_set_i | input | 1 | 1 = set bit, 0 = clear bit |
| bop_addr_i | input | ADDR_W | Bit command address |
| bop_idx_i | input | 3 | Bit index |
| err_o | output | 1 | Rejected bit command pulse |
| pin_i | input | 8*NPORTS | Port input pins, port p in byte p |
| dir_o | output | 8*NPORTS | Direction registers, port p in byte p |
| out_o | output | 8*NPORTS | Output registers, port p in byte p |

## Verification
The bench targets the collision between a byte write and a bit command on one register. A design that let the bit command win would leave a stray bit in the written value. It also fires bit commands just above 0x1F. A decoder that used only the low five address bits would wrongly modify an alias there and give no error. Bit-clear commands on a flag alias check that no flag bit drops, and writes to input registers check that no stored value appears in place of the pin sample. Random mixes of alias and full-map accesses to the same ports expose any split between the two paths to one register.

// File: rtl/lowio_pkg.sv
package lowio_pkg;
  // Enum values equal the full-map offsets inside a port bank
  typedef enum logic [3:0] {
    K_DIR     = 4'd0,
    K_DIRSET  = 4'd1,
    K_DIRCLR  = 4'd2,
    K_DIRTGL  = 4'd3,
    K_OUT     = 4'd4,
    K_OUTSET  = 4'd5,
    K_OUTCLR  = 4'd6,
    K_OUTTGL  = 4'd7,
    K_IN      = 4'd8,
    K_FLAG    = 4'd9,
    K_NONE    = 4'd10
  } reg_kind_e;

  localparam int LOW_SPAN     = 32;
  localparam int LOW_W        = $clog2(LOW_SPAN);
  localparam int ALIAS_BASE   = 4;
  localparam int ALIAS_STRIDE = 4;
  localparam int FULL_BASE    = 64;
  localparam int FULL_STRIDE  = 16;
  localparam int FULL_REGS    = 10;
endpackage

// File: rtl/lowio_decode.sv
module lowio_decode
  import lowio_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NPORTS = 4,
  localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              low_o,
  output logic              hit_o,
  output logic [PW-1:0]     port_o,
  output reg_kind_e         kind_o
);
  always_comb begin
    int a;
    a      = int'(addr_i);
    low_o  = (a < LOW_SPAN);
    hit_o  = 1'b0;
    port_o = '0;
    kind_o = K_NONE;
    for (int p = 0; p < NPORTS; p++) begin
      int ab;
      int fb;
      ab = ALIAS_BASE + p * ALIAS_STRIDE;
      fb = FULL_BASE + p * FULL_STRIDE;
      if ((ab + ALIAS_STRIDE <= LOW_SPAN) && (a >= ab) && (a < ab + ALIAS_STRIDE)) begin
        hit_o  = 1'b1;
        port_o = PW'(p);
        case (a - ab)
          0:       kind_o = K_DIR;
          1:       kind_o = K_OUT;
          2:       kind_o = K_IN;
          default: kind_o = K_FLAG;
        endcase
      end else if ((a >= fb) && (a < fb + FULL_REGS)) begin
        hit_o  = 1'b1;
        port_o = PW'(p);
        kind_o = reg_kind_e'(4'(a - fb));
      end
    end
  end
endmodule

// File: rtl/lowio_bitop.sv
module lowio_bitop
  import lowio_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NPORTS = 4,
  localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic              bop_valid_i,
  input  logic              bop_set_i,
  input  logic [ADDR_W-1:0] bop_addr_i,
  input  logic [2:0]        bop_idx_i,
  output logic              bit_vld_o,
  output logic              bit_set_o,
  output logic [PW-1:0]     bit_port_o,
  output reg_kind_e         bit_kind_o,
  output logic [7:0]        bit_mask_o,
  output logic              reject_o
);
  logic low, hit;

  lowio_decode #(.ADDR_W(ADDR_W), .NPORTS(NPORTS)) u_dec (
    .addr_i (bop_addr_i),
    .low_o  (low),
    .hit_o  (hit),
    .port_o (bit_port_o),
    .kind_o (bit_kind_o)
  );

  assign bit_vld_o  = bop_valid_i && low && hit;
  assign reject_o   = bop_valid_i && !low;
  assign bit_set_o  = bop_set_i;
  assign bit_mask_o = 8'(1) << bop_idx_i;
endmodule

// File: rtl/lowio_port.sv
module lowio_port
  import lowio_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       byte_wr_i,
  input  reg_kind_e  byte_kind_i,
  input  logic [7:0] wdata_i,
  input  logic       bit_vld_i,
  input  logic       bit_set_i,
  input  reg_kind_e  bit_kind_i,
  input  logic [7:0] bit_mask_i,
  input  logic [7:0] pin_i,
  output logic [7:0] dir_o,
  output logic [7:0] out_o,
  output logic [7:0] in_o,
  output logic [7:0] flag_o
);
  logic [7:0] dir_q, out_q, in_q, in_d, flag_q;
  logic [7:0] dir_n, out_n, flag_clr, rise;
  logic       byte_dir, byte_out, byte_flag;

  // op code: 0 write, 1 set, 2 clear, 3 toggle
  function automatic logic [7:0] apply_op(input logic [7:0] cur, input logic [7:0] wd,
                                          input logic [1:0] op);
    case (op)
      2'd0:    return wd;
      2'd1:    return cur | wd;
      2'd2:    return cur & ~wd;
      default: return cur ^ wd;
    endcase
  endfunction

  assign byte_dir  = byte_wr_i && (byte_kind_i inside {K_DIR, K_DIRSET, K_DIRCLR, K_DIRTGL});
  assign byte_out  = byte_wr_i && (byte_kind_i inside {K_OUT, K_OUTSET, K_OUTCLR, K_OUTTGL});
  assign byte_flag = byte_wr_i && (byte_kind_i == K_FLAG);
  assign rise      = in_q & ~in_d;

  always_comb begin
    dir_n = dir_q;
    if (byte_dir)
      dir_n = apply_op(dir_q, wdata_i, byte_kind_i[1:0]);
    else if (bit_vld_i && bit_kind_i == K_DIR)
      dir_n = bit_set_i ? (dir_q | bit_mask_i) : (dir_q & ~bit_mask_i);
  end

  always_comb begin
    out_n = out_q;
    if (byte_out)
      out_n = apply_op(out_q, wdata_i, byte_kind_i[1:0]);
    else if (bit_vld_i && bit_kind_i == K_OUT)
      out_n = bit_set_i ? (out_q | bit_mask_i) : (out_q & ~bit_mask_i);
  end

  // Flag is write-one-to-clear; bit-set clears, bit-clear does nothing
  always_comb begin
    flag_clr = 8'h00;
    if (byte_flag)
      flag_clr = wdata_i;
    else if (bit_vld_i && bit_kind_i == K_FLAG && bit_set_i)
      flag_clr = bit_mask_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= 8'h00;
      out_q  <= 8'h00;
      in_q   <= 8'h00;
      in_d   <= 8'h00;
      flag_q <= 8'h00;
    end else begin
      dir_q  <= dir_n;
      out_q  <= out_n;
      in_q   <= pin_i;
      in_d   <= in_q;
      flag_q <= (flag_q & ~flag_clr) | rise;
    end
  end

  assign dir_o  = dir_q;
  assign out_o  = out_q;
  assign in_o   = in_q;
  assign flag_o = flag_q;

  AST_BYTE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_wr_i && byte_kind_i == K_DIR) |=> (dir_q == $past(wdata_i))); // R9
  AST_ONE_BIT_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_vld_i && bit_kind_i == K_OUT && !byte_out) |=> ($countones(out_q ^ $past(out_q)) <= 1)); // R4
  AST_FLAG_CLRBIT_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_vld_i && bit_kind_i == K_FLAG && !bit_set_i && !byte_flag)
      |=> (($past(flag_q) & ~flag_q) == 8'h00)); // R8
endmodule

// File: rtl/lowio_window.sv
module lowio_window
  import lowio_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NPORTS = 4,
  localparam int PW   = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int PINS = NPORTS * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              bop_valid_i,
  input  logic              bop_set_i,
  input  logic [ADDR_W-1:0] bop_addr_i,
  input  logic [2:0]        bop_idx_i,
  output logic              err_o,
  input  logic [PINS-1:0]   pin_i,
  output logic [PINS-1:0]   dir_o,
  output logic [PINS-1:0]   out_o
);
  logic          wr_en;
  logic          byte_low, byte_hit;
  logic [PW-1:0] byte_port;
  reg_kind_e     byte_kind;

  logic          bit_vld, bit_set, bop_reject;
  logic [PW-1:0] bit_port;
  reg_kind_e     bit_kind;
  logic [7:0]    bit_mask;

  logic [7:0] dir_w [NPORTS];
  logic [7:0] out_w [NPORTS];
  logic [7:0] in_w  [NPORTS];
  logic [7:0] flag_w[NPORTS];

  assign wr_en = req_i && we_i;

  lowio_decode #(.ADDR_W(ADDR_W), .NPORTS(NPORTS)) u_byte_dec (
    .addr_i (addr_i),
    .low_o  (byte_low),
    .hit_o  (byte_hit),
    .port_o (byte_port),
    .kind_o (byte_kind)
  );

  lowio_bitop #(.ADDR_W(ADDR_W), .NPORTS(NPORTS)) u_bitop (
    .bop_valid_i (bop_valid_i),
    .bop_set_i   (bop_set_i),
    .bop_addr_i  (bop_addr_i),
    .bop_idx_i   (bop_idx_i),
    .bit_vld_o   (bit_vld),
    .bit_set_o   (bit_set),
    .bit_port_o  (bit_port),
    .bit_kind_o  (bit_kind),
    .bit_mask_o  (bit_mask),
    .reject_o    (bop_reject)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    lowio_port u_port (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .byte_wr_i   (wr_en && byte_hit && byte_port == PW'(p)),
      .byte_kind_i (byte_kind),
      .wdata_i     (wdata_i),
      .bit_vld_i   (bit_vld && bit_port == PW'(p)),
      .bit_set_i   (bit_set),
      .bit_kind_i  (bit_kind),
      .bit_mask_i  (bit_mask),
      .pin_i       (pin_i[p*8 +: 8]),
      .dir_o       (dir_w[p]),
      .out_o       (out_w[p]),
      .in_o        (in_w[p]),
      .flag_o      (flag_w[p])
    );
    assign dir_o[p*8 +: 8] = dir_w[p];
    assign out_o[p*8 +: 8] = out_w[p];
  end

  always_comb begin
    rdata_o = 8'h00;
    if (req_i && !we_i && byte_hit) begin
      for (int p = 0; p < NPORTS; p++) begin
        if (byte_port == PW'(p)) begin
          case (byte_kind)
            K_DIR, K_DIRSET, K_DIRCLR, K_DIRTGL: rdata_o = dir_w[p];
            K_OUT, K_OUTSET, K_OUTCLR, K_OUTTGL: rdata_o = out_w[p];
            K_IN:                                rdata_o = in_w[p];
            K_FLAG:                              rdata_o = flag_w[p];
            default:                             rdata_o = 8'h00;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_o <= 1'b0;
    else         err_o <= bop_reject;
  end

  AST_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ($past(bop_valid_i) && $past(|bop_addr_i[ADDR_W-1:LOW_W]))); // R5
  AST_HIGH_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bop_valid_i && (|bop_addr_i[ADDR_W-1:LOW_W]) && !wr_en)
      |=> ($stable(dir_o) && $stable(out_o))); // R5
  AST_RESERVED_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && byte_low && !byte_hit && !bop_valid_i)
      |=> ($stable(dir_o) && $stable(out_o))); // R6
endmodule

// File: tb/lowio_window_test.sv
`timescale 1ns/1ps
module lowio_window_test;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req, we, bv, bs;
  logic [7:0]  addr, wdata, ba, rdata;
  logic [2:0]  bi;
  logic        err;
  logic [NP*8-1:0] pins, dir, out;

  lowio_window #(.ADDR_W(8), .NPORTS(NP)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .bop_valid_i(bv), .bop_set_i(bs),
    .bop_addr_i(ba), .bop_idx_i(bi), .err_o(err), .pin_i(pins),
    .dir_o(dir), .out_o(out)
  );

  int checks = 0, failures = 0;
  bit done = 0;
  logic [7:0] m_dir[NP], m_out[NP], m_in[NP], m_ind[NP], m_flag[NP];
  logic [7:0] last_rd;
  logic [NP*8-1:0] pv_cur = '0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // kind: 0..3 dir group, 4..7 out group, 8 input, 9 flag; -1 none
  function automatic void bdec(input logic [7:0] a, output int p, output int k);
    int ai = int'(a);
    p = -1; k = -1;
    if (ai >= 4 && ai < 4 + 4 * NP) begin
      p = (ai - 4) / 4;
      case ((ai - 4) % 4)
        0: k = 0;
        1: k = 4;
        2: k = 8;
        default: k = 9;
      endcase
    end else if (ai >= 64 && ai < 64 + 16 * NP && (ai - 64) % 16 < 10) begin
      p = (ai - 64) / 16;
      k = (ai - 64) % 16;
    end
  endfunction

  function automatic int grp(input int k);
    if (k < 4) return 0;
    if (k < 8) return 1;
    if (k == 9) return 2;
    return 3;
  endfunction

  function automatic logic [7:0] m_read(input logic [7:0] a);
    int p, k;
    bdec(a, p, k);
    if (p < 0) return 8'h00;
    case (grp(k))
      0: return m_dir[p];
      1: return m_out[p];
      2: return m_flag[p];
      default: return m_in[p];
    endcase
  endfunction

  function automatic logic [7:0] bop(input logic [7:0] c, input logic [7:0] d, input int op);
    case (op)
      0: return d;
      1: return c | d;
      2: return c & ~d;
      default: return c ^ d;
    endcase
  endfunction

  task automatic cyc(string tag, bit r, bit w, logic [7:0] a, logic [7:0] d,
                     bit b_en, bit b_set, logic [7:0] b_a, logic [2:0] b_i);
    logic [7:0] nd[NP], no[NP], nf[NP], clr[NP];
    int p, k, q, kb;
    bit e_err;
    @(negedge clk);
    req = r || w; we = w; addr = a; wdata = d;
    bv = b_en; bs = b_set; ba = b_a; bi = b_i; pins = pv_cur;
    #1;
    if (r && !w) begin
      last_rd = rdata;
      chk(tag, "rdata", rdata, m_read(a));
    end
    for (int i = 0; i < NP; i++) begin
      nd[i] = m_dir[i]; no[i] = m_out[i]; clr[i] = 8'h00;
    end
    p = -1; k = -1;
    if (w) bdec(a, p, k);
    if (p >= 0) begin
      if (grp(k) == 0) nd[p] = bop(m_dir[p], d, k);
      else if (grp(k) == 1) no[p] = bop(m_out[p], d, k - 4);
      else if (k == 9) clr[p] = d;
    end
    e_err = b_en && (b_a >= 8'h20);
    if (b_en && !e_err) begin
      bdec(b_a, q, kb);
      if (q >= 0 && !(p == q && grp(k) == grp(kb))) begin
        if (kb == 0) nd[q] = b_set ? (m_dir[q] | (8'(1) << b_i)) : (m_dir[q] & ~(8'(1) << b_i));
        else if (kb == 4) no[q] = b_set ? (m_out[q] | (8'(1) << b_i)) : (m_out[q] & ~(8'(1) << b_i));
        else if (kb == 9 && b_set) clr[q] = 8'(1) << b_i;
      end
    end
    for (int i = 0; i < NP; i++) nf[i] = (m_flag[i] & ~clr[i]) | (m_in[i] & ~m_ind[i]);
    @(posedge clk);
    #1;
    for (int i = 0; i < NP; i++) begin
      m_dir[i] = nd[i]; m_out[i] = no[i]; m_flag[i] = nf[i];
      m_ind[i] = m_in[i]; m_in[i] = pv_cur[i*8 +: 8];
    end
    chk(tag, "err_o", {31'd0, err}, {31'd0, e_err});
    for (int i = 0; i < NP; i++) begin
      chk(tag, "dir_o", dir[i*8 +: 8], m_dir[i]);
      chk(tag, "out_o", out[i*8 +: 8], m_out[i]);
    end
  endtask

  task automatic rdlit(string tag, logic [7:0] a, logic [7:0] exp);
    cyc(tag, 1, 0, a, 8'h00, 0, 0, 8'h00, 3'd0);
    chk(tag, "literal", last_rd, exp);
  endtask

  task automatic wr(string tag, logic [7:0] a, logic [7:0] d);
    cyc(tag, 0, 1, a, d, 0, 0, 8'h00, 3'd0);
  endtask

  task automatic bit_op(string tag, logic [7:0] a, bit s, logic [2:0] i);
    cyc(tag, 0, 0, 8'h00, 8'h00, 1, s, a, i);
  endtask

  function automatic logic [7:0] raddr();
    int s = int'($urandom % 10);
    if (s < 5) return 8'($urandom % 32);
    if (s < 9) return 8'(64 + $urandom % (16 * NP));
    return 8'($urandom);
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    req = 0; we = 0; addr = 0; wdata = 0; bv = 0; bs = 0; ba = 0; bi = 0; pins = '0;
    for (int i = 0; i < NP; i++) begin
      m_dir[i] = 0; m_out[i] = 0; m_in[i] = 0; m_ind[i] = 0; m_flag[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", "dir_o", dir, '0);
    chk("R1", "out_o", out, '0);
    chk("R1", "err_o", {31'd0, err}, 32'd0);
    rdlit("R1", 8'h40, 8'h00);
    rdlit("R1", 8'h49, 8'h00);
    // R3 alias and full map share storage
    wr("R3", 8'h04, 8'hA5);
    rdlit("R3", 8'h40, 8'hA5);
    wr("R3", 8'h54, 8'h3C);
    rdlit("R3", 8'h09, 8'h3C);
    // R2 strobes
    wr("R2", 8'h41, 8'h0A);
    rdlit("R2", 8'h40, 8'hAF);
    wr("R2", 8'h42, 8'h0F);
    wr("R2", 8'h43, 8'hFF);
    rdlit("R2", 8'h43, 8'h5F);
    // R4 single bit set / clear
    bit_op("R4", 8'h0D, 1, 3'd3);
    rdlit("R4", 8'h0D, 8'h08);
    bit_op("R4", 8'h04, 0, 3'd0);
    rdlit("R4", 8'h04, 8'h5E);
    // R5 bit command above window
    bit_op("R5", 8'h44, 1, 3'd7);
    rdlit("R5", 8'h44, 8'h00);
    bit_op("R5", 8'h20, 1, 3'd0);
    // R6 reserved / unmapped low locations
    wr("R6", 8'h02, 8'hFF);
    bit_op("R6", 8'h01, 1, 3'd0);
    rdlit("R6", 8'h02, 8'h00);
    rdlit("R6", 8'h1F, 8'h00);
    // R7 input register
    pv_cur[24 +: 8] = 8'h81;
    rdlit("R7", 8'h12, 8'h00);
    rdlit("R7", 8'h12, 8'h81);
    wr("R7", 8'h12, 8'h00);
    bit_op("R7", 8'h12, 0, 3'd0);
    rdlit("R7", 8'h78, 8'h81);
    // R8 flag behaviour
    rdlit("R8", 8'h13, 8'h81);
    bit_op("R8", 8'h13, 0, 3'd7);
    rdlit("R8", 8'h13, 8'h81);
    bit_op("R8", 8'h13, 1, 3'd0);
    rdlit("R8", 8'h79, 8'h80);
    wr("R8", 8'h79, 8'h80);
    rdlit("R8", 8'h13, 8'h00);
    // R9 byte write beats bit command
    cyc("R9", 0, 1, 8'h40, 8'h33, 1, 1, 8'h04, 3'd7);
    rdlit("R9", 8'h04, 8'h33);
    cyc("R9", 0, 1, 8'h45, 8'h01, 1, 1, 8'h05, 3'd6);
    rdlit("R9", 8'h05, 8'h01);
    // Random mix, all requirements via model (R2 R3 R4 R5 R6 R7 R8 R9)
    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom % 10);
      bit be = ($urandom % 2) == 1;
      logic [7:0] b_a = (($urandom % 10) < 7) ? 8'($urandom % 32) : raddr();
      if (($urandom % 10) == 0) pv_cur = NP * 8'($urandom);
      if (($urandom % 10) == 0) pv_cur = {$urandom};
      cyc("R2-mix", r < 3, (r >= 3) && (r < 8), raddr(), 8'($urandom),
          be, ($urandom % 2) == 1, b_a, 3'($urandom));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule